// File: doc/BRIEF.md
# Bit-stuffing HDLC frame transmitter

This block serializes one frame at a time onto a synchronous serial line. Bytes are offered on a valid/ready stream, and a last marker ends the frame. The first byte is taken as the address field and the second as the control field. Any further bytes are payload. The link supplies a clock enable, and the block emits exactly one line bit on each enabled cycle.

Every frame is wrapped in 0x7E flags. The frame body is followed by a 16-bit frame check sequence. A zero is inserted after any five consecutive ones in the body or the check sequence, so the flag pattern never appears inside a frame. When no frame is pending, the line carries continuous flags.

Top module: `hdlc_framer_tx`

## Requirements
- R1: After reset, `line_bit` is 1 and `frm_ready` is 0. `line_bit` changes only on an edge where `line_en` is high, and takes exactly one new bit on each such edge.
- R2: While no frame is pending, the line carries back-to-back flags. Each flag is the octet 0x7E sent least significant bit first, so the line sees 0,1,1,1,1,1,1,0. The first flag starts at the first enabled edge after reset.
- R3: A pending frame starts at the end of the flag in progress. Its first byte is accepted on the enabled edge that emits that flag's last bit. Every byte is sent least significant bit first, in the order accepted: address, then control, then payload.
- R4: The check sequence uses the CRC-16 polynomial x^16+x^12+x^5+1, processed least significant bit first (reversed constant 0x8408). The register is preset to 0xFFFF. Its ones' complement is sent least significant bit first, straight after the last byte. It covers only the unstuffed frame bytes, so the nine ASCII bytes "123456789" give the value 0x906E.
- R5: Inside a frame, including the check sequence, a 0 is inserted after every run of five 1s. The run count restarts after each inserted 0, so the line never shows six 1s between the opening and closing flags.
- R6: Flags are never stuffed, and the run count clears at each flag. A closing flag follows the check sequence at once, or follows the inserted 0 that the check sequence's final run of ones requires.
- R7: `frm_ready` is high only on a cycle with `line_en` high, when the next byte is needed, and never while an inserted 0 is going out. A byte is taken when `frm_valid` and `frm_ready` are both high, and no accepted byte is lost or repeated.
- R8: If `frm_valid` is low when the next byte of an unfinished frame is needed, the frame is closed. Its check sequence then covers only the bytes accepted so far.
- R9: When a new frame is waiting as one frame closes, the closing flag also serves as the opening flag of the next frame. The next frame's first bit follows that flag directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_en | input | 1 | Bit-rate enable from the link; one line bit per high cycle |
| frm_valid | input | 1 | Frame byte offered |
| frm_data | input | 8 | Frame byte (address, control, then payload) |
| frm_last | input | 1 | Marks the final byte of the frame |
| frm_ready | output | 1 | Byte accepted on this edge when frm_valid is high |
| line_bit | output | 1 | Serial line output |

## Verification
`line_bit` is registered. The bit chosen on an enabled edge is visible just after that edge, so the bench captures one bit per enabled edge, two nanoseconds after it. Bit N of the stream is the value after the N-th enabled edge. A handshake is sampled one nanosecond after the falling edge, before the rising edge that consumes it. The bench records the bit index of the first accepted byte, which is the last bit of the opening flag. The frame's first data bit is due on the very next enable, and the expected stuffed sequence, closing flag and decoded check value are compared from that index onward. Each frame is checked only after enough enables have passed for its closing flag to appear.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [1:0] {
        PH_FLAG = 2'd0,
        PH_BODY = 2'd1,
        PH_FCS  = 2'd2
    } phase_e;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [15:0] CRC_REV_POLY = 16'h8408;
    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h8408,
    parameter logic [15:0] SEED  = 16'hFFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    input  logic feed,
    input  logic feed_bit,
    input  logic emit,
    output logic fcs_bit
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_s;

    crc_s st_d, st_q;
    logic fb;

    assign fcs_bit = ~st_q.crc[0];

    always_comb begin
        st_d = st_q;
        fb   = st_q.crc[0] ^ feed_bit;
        if (step) begin
            if (clr) begin
                st_d.crc = SEED[CRC_W-1:0];
            end else if (feed) begin
                st_d.crc = (st_q.crc >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
            end else if (emit) begin
                st_d.crc = st_q.crc >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: SEED[CRC_W-1:0]};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic raw_bit,
    input  logic raw_is_flag,
    output logic hold,
    output logic tx_bit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
        logic          pend;
        logic          tx;
    } zi_s;

    zi_s st_d, st_q;

    assign hold   = st_q.pend;
    assign tx_bit = st_q.tx;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.pend) begin
                st_d.tx   = 1'b0;
                st_d.pend = 1'b0;
                st_d.ones = '0;
            end else begin
                st_d.tx = raw_bit;
                if (raw_is_flag || !raw_bit) begin
                    st_d.ones = '0;
                end else if (st_q.ones == CW'(RUN_LEN - 1)) begin
                    st_d.ones = '0;
                    st_d.pend = 1'b1;
                end else begin
                    st_d.ones = st_q.ones + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ones: '0, pend: 1'b0, tx: 1'b1};
        else        st_q <= st_d;
    end

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ones < CW'(RUN_LEN));
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int               BYTE_W = 8,
    parameter int               FCS_W  = 16,
    parameter logic [BYTE_W-1:0] FLAG  = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              hold,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              fcs_bit,
    output logic              raw_bit,
    output logic              raw_is_flag,
    output logic              advance,
    output logic              crc_clr,
    output logic              crc_feed,
    output logic              crc_emit
);
    localparam int MAXW  = (BYTE_W > FCS_W) ? BYTE_W : FCS_W;
    localparam int CNT_W = $clog2(MAXW);
    localparam int BI_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(FCS_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              last;
    } seq_s;

    seq_s st_d, st_q;

    assign advance = bit_en && !hold;

    always_comb begin
        st_d        = st_q;
        in_ready    = 1'b0;
        raw_bit     = 1'b1;
        raw_is_flag = 1'b0;
        crc_clr     = 1'b0;
        crc_feed    = 1'b0;
        crc_emit    = 1'b0;
        case (st_q.ph)
            PH_FLAG: begin
                raw_bit     = FLAG[st_q.cnt[BI_W-1:0]];
                raw_is_flag = 1'b1;
                crc_clr     = 1'b1;
                if (advance) begin
                    if (st_q.cnt == BYTE_END) begin
                        st_d.cnt = '0;
                        in_ready = 1'b1;
                        if (in_valid) begin
                            st_d.ph   = PH_BODY;
                            st_d.sh   = in_data;
                            st_d.last = in_last;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_BODY: begin
                raw_bit  = st_q.sh[0];
                crc_feed = 1'b1;
                if (advance) begin
                    st_d.sh = st_q.sh >> 1;
                    if (st_q.cnt == BYTE_END) begin
                        st_d.cnt = '0;
                        if (!st_q.last) begin
                            in_ready = 1'b1;
                            if (in_valid) begin
                                st_d.sh   = in_data;
                                st_d.last = in_last;
                            end else begin
                                st_d.ph = PH_FCS;
                            end
                        end else begin
                            st_d.ph = PH_FCS;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_FCS: begin
                raw_bit  = fcs_bit;
                crc_emit = 1'b1;
                if (advance) begin
                    if (st_q.cnt == FCS_END) begin
                        st_d.cnt = '0;
                        st_d.ph  = PH_FLAG;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.ph  = PH_FLAG;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_FLAG, cnt: '0, sh: '0, last: 1'b0};
        else        st_q <= st_d;
    end

    // R6
    flag_unstuffed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(st_q.ph == PH_FLAG && st_q.cnt != '0));
endmodule

// File: rtl/hdlc_framer_tx.sv
module hdlc_framer_tx
    import hdlc_tx_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FCS_W   = 16,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_en,
    input  logic              frm_valid,
    input  logic [BYTE_W-1:0] frm_data,
    input  logic              frm_last,
    output logic              frm_ready,
    output logic              line_bit
);
    logic hold, raw_bit, raw_is_flag, advance;
    logic crc_clr, crc_feed, crc_emit, fcs_bit;

    hdlc_tx_seq #(
        .BYTE_W (BYTE_W),
        .FCS_W  (FCS_W),
        .FLAG   (FLAG_OCTET[BYTE_W-1:0])
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (line_en),
        .hold        (hold),
        .in_valid    (frm_valid),
        .in_data     (frm_data),
        .in_last     (frm_last),
        .in_ready    (frm_ready),
        .fcs_bit     (fcs_bit),
        .raw_bit     (raw_bit),
        .raw_is_flag (raw_is_flag),
        .advance     (advance),
        .crc_clr     (crc_clr),
        .crc_feed    (crc_feed),
        .crc_emit    (crc_emit)
    );

    hdlc_crc16 #(
        .CRC_W (FCS_W),
        .POLY  (CRC_REV_POLY),
        .SEED  (CRC_SEED)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (advance),
        .clr      (crc_clr),
        .feed     (crc_feed),
        .feed_bit (raw_bit),
        .emit     (crc_emit),
        .fcs_bit  (fcs_bit)
    );

    hdlc_zero_ins #(
        .RUN_LEN (RUN_LEN)
    ) u_zins (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (line_en),
        .raw_bit     (raw_bit),
        .raw_is_flag (raw_is_flag),
        .hold        (hold),
        .tx_bit      (line_bit)
    );

    // R1
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> $stable(line_bit));

    // R7
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> (line_en && !hold));

    // R5
    stuff_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> line_bit);
endmodule

// File: tb/hdlc_framer_tx_bench.sv
module hdlc_framer_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_en = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic       frm_last = 1'b0;
    logic       frm_ready;
    logic       line_bit;

    hdlc_framer_tx u_hdlc_framer_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_en   (line_en),
        .frm_valid (frm_valid),
        .frm_data  (frm_data),
        .frm_last  (frm_last),
        .frm_ready (frm_ready),
        .line_bit  (line_bit)
    );

    always #4 clk = ~clk;

    localparam logic [7:0] FLAGB = 8'h7E;
    localparam int NV = 5;
    localparam logic [7:0] VB [0:NV-1][0:4] = '{
        '{8'h03, 8'h3F, 8'h00, 8'h00, 8'h00},
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00},
        '{8'h7E, 8'h7E, 8'h7E, 8'h00, 8'h00},
        '{8'h00, 8'hF8, 8'h1F, 8'hAA, 8'h55},
        '{8'hC1, 8'h5A, 8'h3C, 8'h00, 8'h00}
    };
    localparam int VL    [0:NV-1] = '{2, 4, 3, 5, 3};
    localparam bit VLAST [0:NV-1] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int VDIV  [0:NV-1] = '{1, 1, 2, 3, 1};

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int div = 1;
    int dcnt = 0;
    bit en_gate = 1'b0;
    always @(negedge clk) begin
        if (!en_gate) begin
            line_en = 1'b0;
            dcnt = 0;
        end else begin
            line_en = (dcnt == 0);
            dcnt = (dcnt + 1 >= div) ? 0 : dcnt + 1;
        end
    end

    logic cap [0:16383];
    int   nbits = 0;
    logic en_s;
    always @(posedge clk) begin
        en_s = line_en;
        #2;
        if (en_s) begin
            cap[nbits] = line_bit;
            nbits++;
        end
    end

    logic [7:0] fb [0:15];
    logic       xb [0:1023];
    int         xn;

    task automatic wait_bits(input int k);
        int target;
        target = nbits + k;
        while (nbits < target) @(negedge clk);
    endtask

    task automatic send(input int n, input bit lastset, output int start);
        start = -1;
        for (int i = 0; i < n; i++) begin
            bit took;
            took = 1'b0;
            @(negedge clk);
            while (!took) begin
                frm_valid = 1'b1;
                frm_data  = fb[i];
                frm_last  = lastset && (i == n - 1);
                #1;
                if (frm_ready) begin
                    if (i == 0) start = nbits;
                    took = 1'b1;
                end
                @(negedge clk);
            end
        end
        frm_valid = 1'b0;
        frm_last  = 1'b0;
    endtask

    task automatic build_exp(input int n);
        logic [15:0] c;
        logic        raw [0:255];
        int          rn;
        int          ones;
        logic        b;
        logic        f;
        c  = 16'hFFFF;
        rn = 0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                b = fb[i][k];
                raw[rn] = b;
                rn++;
                f = c[0] ^ b;
                c = c >> 1;
                if (f) c = c ^ 16'h8408;
            end
        end
        for (int k = 0; k < 16; k++) begin
            raw[rn] = ~c[k];
            rn++;
        end
        xn = 0;
        ones = 0;
        for (int i = 0; i < rn; i++) begin
            xb[xn] = raw[i];
            xn++;
            if (raw[i]) begin
                ones++;
                if (ones == 5) begin
                    xb[xn] = 1'b0;
                    xn++;
                    ones = 0;
                end
            end else begin
                ones = 0;
            end
        end
        for (int k = 0; k < 8; k++) begin
            xb[xn] = FLAGB[k];
            xn++;
        end
    endtask

    task automatic check_frame(input int st, input string tag);
        int bad;
        int first;
        int run;
        int maxrun;
        logic got_flag [0:7];
        bit flag_ok;
        bad = 0;
        first = -1;
        for (int i = 0; i < xn - 8; i++) begin
            if (cap[st + 1 + i] !== xb[i]) begin
                if (first < 0) first = i;
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s R3 R7 body bit %0d: got %0b exp %0b (%0d mismatches)",
                     tag, first, cap[st + 1 + first], xb[first], bad);
        end
        flag_ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            got_flag[k] = cap[st + xn - 7 + k];
            if (got_flag[k] !== FLAGB[k]) flag_ok = 1'b0;
        end
        checks++;
        if (!flag_ok) begin
            fails++;
            $display("FAIL %s R6 closing flag: got %0b%0b%0b%0b%0b%0b%0b%0b exp 01111110",
                     tag, got_flag[0], got_flag[1], got_flag[2], got_flag[3],
                     got_flag[4], got_flag[5], got_flag[6], got_flag[7]);
        end
        run = 0;
        maxrun = 0;
        for (int i = st + 1; i <= st + xn - 8; i++) begin
            run = cap[i] ? run + 1 : 0;
            if (run > maxrun) maxrun = run;
        end
        checks++;
        if (maxrun > 5) begin
            fails++;
            $display("FAIL %s R5 longest ones run inside frame: got %0d exp <=5", tag, maxrun);
        end
    endtask

    task automatic decode_fcs(input int st, input int n, output logic [15:0] f);
        int p;
        int ones;
        int cnt;
        logic b;
        p = st + 1;
        ones = 0;
        cnt = 0;
        f = '0;
        while (cnt < n * 8 + 16) begin
            if (ones == 5) begin
                p++;
                ones = 0;
            end else begin
                b = cap[p];
                p++;
                if (cnt >= n * 8) f[cnt - n * 8] = b;
                cnt++;
                ones = b ? ones + 1 : 0;
            end
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int st;
        int sta;
        int stb;
        int xna;
        logic [15:0] fcs;
        bit idle_ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state with no enables yet
        checks++;
        if (line_bit !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset line_bit: got %0b exp 1", line_bit);
        end
        checks++;
        if (frm_ready !== 1'b0 || nbits != 0) begin
            fails++;
            $display("FAIL R1 reset ready/bits: got %0b/%0d exp 0/0", frm_ready, nbits);
        end

        en_gate = 1'b1;
        wait_bits(24);
        // R2: idle fill is back-to-back flags
        idle_ok = 1'b1;
        for (int i = 0; i < 24; i++) if (cap[i] !== FLAGB[i % 8]) idle_ok = 1'b0;
        checks++;
        if (!idle_ok) begin
            fails++;
            $display("FAIL R2 idle flags: got first bits %0b%0b%0b%0b exp 0111",
                     cap[0], cap[1], cap[2], cap[3]);
        end

        for (int v = 0; v < NV; v++) begin
            div = VDIV[v];
            for (int i = 0; i < VL[v]; i++) fb[i] = VB[v][i];
            send(VL[v], VLAST[v], st);
            build_exp(VL[v]);
            wait_bits(xn + 4);
            if (v == 4) check_frame(st, "R8 underrun");
            else        check_frame(st, "R3 table");
        end

        // R4: known-answer check value
        div = 1;
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        send(9, 1'b1, st);
        build_exp(9);
        wait_bits(xn + 4);
        check_frame(st, "R4 known");
        decode_fcs(st, 9, fcs);
        checks++;
        if (fcs !== 16'h906E) begin
            fails++;
            $display("FAIL R4 check value: got %h exp 906e", fcs);
        end

        // R9: back-to-back frames share one flag
        div = 2;
        fb[0] = 8'h01; fb[1] = 8'h13; fb[2] = 8'hFC;
        send(3, 1'b1, sta);
        build_exp(3);
        xna = xn;
        fb[0] = 8'h02; fb[1] = 8'h73; fb[2] = 8'h1F; fb[3] = 8'hE0;
        send(4, 1'b1, stb);
        checks++;
        if (stb != sta + xna) begin
            fails++;
            $display("FAIL R9 second frame start: got %0d exp %0d", stb, sta + xna);
        end
        build_exp(4);
        wait_bits(xn + 4);
        check_frame(stb, "R9 second");
        fb[0] = 8'h01; fb[1] = 8'h13; fb[2] = 8'hFC;
        build_exp(3);
        check_frame(sta, "R9 first");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule